// File: doc/BRIEF.md
# Auxiliary Address Register Unit

This unit keeps eight general auxiliary registers for a DSP core and carries out the register-side work of the address instructions. It adds an 8-bit constant to a selected register, subtracts it, or loads it, all in a single cycle. It can do the same with a 16-bit constant taken from a second program word, which costs one extra cycle. It can test any register against R5, which acts as the loop-end index. It also generates indirect memory addresses, where one register points at the location that another register is loaded from or stored to.

The sequencer presents a 17-bit instruction word on `instr_i` and pulses `start_i`. For long-constant words, the sequencer supplies the second program word on `const_i` in the cycle that follows, while `busy_o` is high. Memory is external. The unit drives an address, write data and a write strobe, and it accepts read data combinationally in the same cycle. All eight registers are visible on a flat read bus.

Top module: `addr_reg_unit`

## Requirements
- R1: While `rst_ni` is low, all registers are zero, and `eq_o`, `busy_o` and `mem_we_o` are low.
- R2: A short-constant word has bits 16..13 = 1011, operation field in bits 12..11, register field in bits 4..2, and constant bits k4,k3,k2 in bits 10..8, k7,k6,k5 in bits 7..5, and k1,k0 in bits 1..0. The unit rebuilds the constant as k7..k0.
- R3: Operation codes are 00 load, where the constant is zero-extended; 01 add; 10 subtract; 11 compare. Add and subtract wrap modulo 2^16. A short-constant operation updates the register at the clock edge that samples `start_i`.
- R4: Compare (11) sets `eq_o` to (selected register == R5) and changes no register. `eq_o` holds its value until the next compare.
- R5: A long-constant word has bits 16..7 = 1111111000, operation in bits 6..5 and register in bits 4..2. `busy_o` is high for exactly the cycle after the start. `const_i` is used in that cycle, and the register is written at the end of it.
- R6: `start_i` is ignored while `busy_o` is high.
- R7: A memory word has bits 16..12 = 11110, with bit 11 = 0 for load. The data register is in bits 10..8 and the address register in bits 2..0. `mem_addr_o` equals the address register, and the data register takes `mem_rdata_i` at the edge.
- R8: With bit 11 = 1 (store), `mem_we_o` is high in the start cycle and `mem_wdata_o` equals the data register. No register changes.
- R9: When the data register and the address register of a memory word are the same, the address uses that register's value from before the edge.
- R10: Any other word, including the 1111111001 prefix group, changes nothing, and `mem_we_o` stays low.
- R11: All eight registers behave identically. Register i appears on `regs_o[16i+15:16i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Execute the word on instr_i |
| instr_i | input | 17 | Instruction word |
| const_i | input | 16 | Second program word for long-constant forms |
| mem_rdata_i | input | 16 | Memory read data |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| eq_o | output | 1 | Compare-equal flag |
| busy_o | output | 1 | Second cycle of a long-constant operation |
| regs_o | output | 128 | All registers, R0 in the low bits |

## Verification
Address generation and a register write can fall in the same cycle when a load names the same register as both pointer and destination. The bench provokes this by loading R6 through R6. It judges the result by checking that `mem_addr_o` shows the old R6 before the edge and that R6 holds the read data after it. A store that sends the pointer register itself exercises the same read path without a write. An extra start arriving during the busy cycle tests the second overlap, and it must leave every register untouched.

// File: rtl/aru_pkg.sv
package aru_pkg;
  localparam int INSTR_W = 17;
  localparam int SEL_W   = 3;
  localparam int REG_CNT = 1 << SEL_W;
  localparam int IMM_W   = 8;

  typedef enum logic [1:0] {
    OP_LDI = 2'b00,
    OP_ADD = 2'b01,
    OP_SUB = 2'b10,
    OP_CMP = 2'b11
  } aru_op_e;

  typedef enum logic [1:0] {
    FORM_NONE,
    FORM_SHORT,
    FORM_LONG,
    FORM_MEM
  } aru_form_e;

  typedef struct packed {
    aru_form_e         form;
    aru_op_e           op;
    logic [SEL_W-1:0]  reg_sel;
    logic [SEL_W-1:0]  adr_sel;
    logic              store;
    logic [IMM_W-1:0]  imm;
  } aru_dec_t;
endpackage

// File: rtl/aru_decode.sv
module aru_decode
  import aru_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output aru_dec_t           dec_o
);
  always_comb begin
    dec_o = '{form: FORM_NONE, op: OP_LDI, reg_sel: '0, adr_sel: '0, store: 1'b0, imm: '0};
    if (instr_i[16:13] == 4'b1011) begin
      dec_o.form    = FORM_SHORT;
      dec_o.op      = aru_op_e'(instr_i[12:11]);
      dec_o.reg_sel = instr_i[4:2];
      // scattered constant: k7..k5 at 7..5, k4..k2 at 10..8, k1..k0 at 1..0
      dec_o.imm     = {instr_i[7:5], instr_i[10:8], instr_i[1:0]};
    end else if (instr_i[16:12] == 5'b11110) begin
      dec_o.form    = FORM_MEM;
      dec_o.store   = instr_i[11];
      dec_o.reg_sel = instr_i[10:8];
      dec_o.adr_sel = instr_i[2:0];
    end else if (instr_i[16:7] == 10'b1111111000) begin
      dec_o.form    = FORM_LONG;
      dec_o.op      = aru_op_e'(instr_i[6:5]);
      dec_o.reg_sel = instr_i[4:2];
    end
  end
endmodule

// File: rtl/aru_alu.sv
module aru_alu
  import aru_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  aru_op_e             op_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic [DATA_W-1:0]   idx_i,
  output logic [DATA_W-1:0]   res_o,
  output logic                wr_o,
  output logic                eq_o
);
  always_comb begin
    res_o = a_i;
    wr_o  = 1'b1;
    unique case (op_i)
      OP_LDI: res_o = b_i;
      OP_ADD: res_o = a_i + b_i;
      OP_SUB: res_o = a_i - b_i;
      OP_CMP: wr_o  = 1'b0;
      default: wr_o = 1'b0;
    endcase
  end

  assign eq_o = (a_i == idx_i);
endmodule

// File: rtl/aru_regfile.sv
module aru_regfile
  import aru_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [SEL_W-1:0]            waddr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [REG_CNT*DATA_W-1:0]   regs_o
);
  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= '0;
      else if (we_i && waddr_i == SEL_W'(g))      q <= wdata_i;
    end
    assign regs_o[g*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/addr_reg_unit.sv
module addr_reg_unit
  import aru_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [INSTR_W-1:0]          instr_i,
  input  logic [DATA_W-1:0]           const_i,
  input  logic [DATA_W-1:0]           mem_rdata_i,
  output logic [DATA_W-1:0]           mem_addr_o,
  output logic [DATA_W-1:0]           mem_wdata_o,
  output logic                        mem_we_o,
  output logic                        eq_o,
  output logic                        busy_o,
  output logic [REG_CNT*DATA_W-1:0]   regs_o
);
  localparam int PAD_W = DATA_W - IMM_W;

  aru_dec_t          dec;
  logic [DATA_W-1:0] r [REG_CNT];
  logic              pend_q;
  aru_op_e           pend_op_q;
  logic [SEL_W-1:0]  pend_reg_q;
  logic              eq_q;
  logic              accept;
  logic              alu_fire;
  aru_op_e           alu_op;
  logic [DATA_W-1:0] alu_a, alu_b, alu_res;
  logic              alu_wr, alu_eq;
  logic              rf_we;
  logic [SEL_W-1:0]  rf_waddr;
  logic [DATA_W-1:0] rf_wdata;

  aru_decode i_decode (.instr_i(instr_i), .dec_o(dec));

  for (genvar g = 0; g < REG_CNT; g++) begin : g_unpack
    assign r[g] = regs_o[g*DATA_W +: DATA_W];
  end

  assign accept   = start_i && !pend_q;
  assign alu_fire = pend_q || (accept && dec.form == FORM_SHORT);

  // second cycle of a long form owns the ALU
  always_comb begin
    if (pend_q) begin
      alu_op = pend_op_q;
      alu_a  = r[pend_reg_q];
      alu_b  = const_i;
    end else begin
      alu_op = dec.op;
      alu_a  = r[dec.reg_sel];
      alu_b  = {{PAD_W{1'b0}}, dec.imm};
    end
  end

  aru_alu #(.DATA_W(DATA_W)) i_alu (
    .op_i (alu_op),
    .a_i  (alu_a),
    .b_i  (alu_b),
    .idx_i(r[5]),
    .res_o(alu_res),
    .wr_o (alu_wr),
    .eq_o (alu_eq)
  );

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = dec.reg_sel;
    rf_wdata = alu_res;
    if (alu_fire && alu_wr) begin
      rf_we    = 1'b1;
      rf_waddr = pend_q ? pend_reg_q : dec.reg_sel;
    end else if (accept && dec.form == FORM_MEM && !dec.store) begin
      rf_we    = 1'b1;
      rf_wdata = mem_rdata_i;
    end
  end

  aru_regfile #(.DATA_W(DATA_W)) i_regfile (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (rf_we),
    .waddr_i(rf_waddr),
    .wdata_i(rf_wdata),
    .regs_o (regs_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_op_q  <= OP_LDI;
      pend_reg_q <= '0;
      eq_q       <= 1'b0;
    end else begin
      pend_q <= accept && dec.form == FORM_LONG;
      if (accept && dec.form == FORM_LONG) begin
        pend_op_q  <= dec.op;
        pend_reg_q <= dec.reg_sel;
      end
      if (alu_fire && alu_op == OP_CMP) eq_q <= alu_eq;
    end
  end

  assign mem_addr_o  = r[dec.adr_sel];
  assign mem_wdata_o = r[dec.reg_sel];
  assign mem_we_o    = accept && dec.form == FORM_MEM && dec.store;
  assign eq_o        = eq_q;
  assign busy_o      = pend_q;

  assert_busy_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);
  assert_busy_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i && dec.form == FORM_LONG));
  assert_cmp_keeps_regs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && dec.form == FORM_SHORT && dec.op == OP_CMP) |=> $stable(regs_o));
  assert_eq_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alu_fire && alu_op == OP_CMP) |=> $stable(eq_o));
  assert_no_store_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !mem_we_o);
  assert_store_keeps_regs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> $stable(regs_o));
  assert_unknown_inert_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && dec.form == FORM_NONE) |=> $stable(regs_o));
endmodule

// File: tb/test_addr_reg_unit.sv
module test_addr_reg_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] LDI = 2'b00, ADD = 2'b01, SUB = 2'b10, CMP = 2'b11;

  logic         clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [16:0]  instr = '0;
  logic [15:0]  cval = '0;
  logic [15:0]  mem_addr, mem_wdata, mem_rdata;
  logic         mem_we, eq, busy;
  logic [127:0] regs;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_rdata = mem_addr ^ 16'h5A5A;

  addr_reg_unit i_addr_reg_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr), .const_i(cval),
    .mem_rdata_i(mem_rdata), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .eq_o(eq), .busy_o(busy), .regs_o(regs));

  typedef struct {
    int           due;
    string        req;
    logic [127:0] regs;
    logic         eq;
  } exp_t;

  exp_t        q[$];
  logic [15:0] model [8];
  logic        eq_m = 1'b0;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [127:0] pack_model();
    logic [127:0] p;
    for (int i = 0; i < 8; i++) p[i*16 +: 16] = model[i];
    return p;
  endfunction

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(string req);
    exp_t e;
    e.due = cyc + 1; e.req = req; e.regs = pack_model(); e.eq = eq_m;
    q.push_back(e);
  endtask

  // monitor: compare items once their commit edge has passed
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      chk(e.req, "regs", regs, e.regs);
      chk(e.req, "eq", {127'b0, eq}, {127'b0, e.eq});
    end
  end

  function automatic logic [16:0] short_w(logic [1:0] op, logic [2:0] rs, logic [7:0] k);
    return {4'b1011, op, k[4:2], k[7:5], rs, k[1:0]};
  endfunction
  function automatic logic [16:0] long_w(logic [1:0] op, logic [2:0] rs);
    return {10'b1111111000, op, rs, 2'b00};
  endfunction
  function automatic logic [16:0] mem_w(logic st, logic [2:0] d, logic [2:0] a);
    return {5'b11110, st, d, 5'b00000, a};
  endfunction

  task automatic apply(logic [1:0] op, int rs, logic [15:0] k);
    case (op)
      LDI: model[rs] = k;
      ADD: model[rs] = model[rs] + k;
      SUB: model[rs] = model[rs] - k;
      default: eq_m = (model[rs] == model[5]);
    endcase
  endtask

  task automatic issue(logic [16:0] w);
    @(negedge clk);
    start = 1'b1;
    instr = w;
  endtask

  task automatic idle();
    @(negedge clk);
    start = 1'b0;
    instr = '0;
  endtask

  task automatic short_op(logic [1:0] op, int rs, logic [7:0] k, string req);
    issue(short_w(op, 3'(rs), k));
    apply(op, rs, {8'h00, k});
    push(req);
  endtask

  task automatic long_op(logic [1:0] op, int rs, logic [15:0] k, logic [16:0] extra, string req);
    issue(long_w(op, 3'(rs)));
    #1 chk("R5", "busy in start cycle", {127'b0, busy}, 128'd0);
    @(negedge clk);
    instr = extra;           // start held high during busy: must be ignored (R6)
    cval  = k;
    #1 chk("R5", "busy in second cycle", {127'b0, busy}, 128'd1);
    chk("R6", "store strobe while busy", {127'b0, mem_we}, 128'd0);
    apply(op, rs, k);
    push(req);
    idle();
    #1 chk("R5", "busy after completion", {127'b0, busy}, 128'd0);
  endtask

  task automatic mem_op(logic st, int d, int a, string req);
    issue(mem_w(st, 3'(d), 3'(a)));
    #1 chk(req, "address", {112'b0, mem_addr}, {112'b0, model[a]});
    chk(req, "strobe", {127'b0, mem_we}, {127'b0, st});
    if (st) chk("R8", "write data", {112'b0, mem_wdata}, {112'b0, model[d]});
    else    model[d] = model[a] ^ 16'h5A5A;
    push(req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 chk("R1", "regs in reset", regs, 128'd0);
    chk("R1", "eq/busy/we in reset", {125'b0, eq, busy, mem_we}, 128'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2, R11: scattered constant bits into every register
    short_op(LDI, 0, 8'hA5, "R2");
    short_op(LDI, 1, 8'h5A, "R2");
    short_op(LDI, 2, 8'h81, "R11");
    short_op(LDI, 3, 8'h7E, "R11");
    short_op(LDI, 4, 8'h00, "R11");
    short_op(LDI, 5, 8'hE3, "R11");
    short_op(LDI, 6, 8'h1C, "R11");
    short_op(LDI, 7, 8'hFF, "R11");

    // R3: wrap-around add/subtract
    long_op(LDI, 3, 16'hFFF0, short_w(LDI, 0, 8'hEE), "R5");
    short_op(ADD, 3, 8'h20, "R3");
    short_op(SUB, 4, 8'h01, "R3");
    short_op(ADD, 0, 8'h0B, "R3");
    long_op(ADD, 7, 16'h8001, mem_w(1'b1, 3'd1, 3'd2), "R5");
    long_op(SUB, 2, 16'h0100, short_w(ADD, 2, 8'h44), "R6");

    // R4: compare against R5
    long_op(LDI, 5, 16'h1234, short_w(LDI, 5, 8'h00), "R5");
    long_op(LDI, 1, 16'h1234, short_w(LDI, 1, 8'h00), "R5");
    short_op(CMP, 1, 8'h99, "R4");
    short_op(CMP, 2, 8'h00, "R4");
    short_op(CMP, 5, 8'h00, "R4");
    short_op(ADD, 6, 8'h10, "R4");
    long_op(CMP, 2, 16'hFFFF, short_w(LDI, 3, 8'h00), "R4");
    long_op(CMP, 1, 16'h0000, short_w(LDI, 3, 8'h00), "R4");

    // R7, R8, R9: indirect memory access
    mem_op(1'b0, 2, 6, "R7");
    mem_op(1'b0, 6, 6, "R9");
    mem_op(1'b1, 3, 6, "R8");
    mem_op(1'b1, 7, 7, "R9");
    mem_op(1'b0, 0, 7, "R7");

    // R10: foreign words
    issue({10'b1111111001, 7'h55});
    #1 chk("R10", "strobe", {127'b0, mem_we}, 128'd0);
    push("R10");
    issue(17'h00000);
    push("R10");
    issue(17'h1FFFF);
    push("R10");
    idle();

    repeat (3) @(negedge clk);
    chk("R10", "scoreboard drained", {96'b0, 32'(q.size())}, 128'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule